// File: doc/BRIEF.md
# Serial Configuration Slave for a Clock Output Buffer

This block is a write-only two-wire serial slave that holds the configuration of a clock fan-out buffer with ten outputs. It oversamples the serial clock and data lines with the system clock. Each line passes through a two-stage synchronizer and a glitch filter. The block then finds start and stop conditions and shifts bytes in most significant bit first. Only a frame whose first byte is the write address `0xD2` is accepted. The block acknowledges every byte of such a frame and stores three configuration bytes.

The frame is fixed. It starts with the address byte, followed by a command byte and a count byte, which are both consumed and ignored. Seven data bytes follow. Data bytes 0, 1 and 2 land in the configuration registers. Data bytes 3 to 6 and any bytes past the tenth are acknowledged and discarded. The enable of output `i` is bit `i` of the 24-bit configuration word `{data2, data1, data0}`, so data0 bit k controls output k and data1 bits 1:0 control outputs 8 and 9. Each enable is gated by the hardware output-enable pin.

The frame controller has six states:
- `ST_IDLE` waits for a start.
- `ST_ADDR` shifts the address.
- `ST_ADDR_ACK` drives the address acknowledge.
- `ST_DATA` shifts a frame byte.
- `ST_DATA_ACK` drives the byte acknowledge.
- `ST_IGNORE` sits out a transaction addressed elsewhere.

Transitions:
- A start moves any state to `ST_ADDR`.
- A stop moves any state to `ST_IDLE`.
- In `ST_ADDR`, the falling clock after eight bits goes to `ST_ADDR_ACK` on a match and to `ST_IGNORE` otherwise.
- In `ST_ADDR_ACK` and `ST_DATA_ACK`, the ninth falling clock goes to `ST_DATA`.
- In `ST_DATA`, the falling clock after eight bits goes to `ST_DATA_ACK` and commits the byte.

Top module: `smb_cfg_slave`

## Requirements
- R1: After reset all 24 configuration bits read 1, so every output enable equals the output-enable pin.
- R2: After an address byte of `0xD2`, the slave pulls SDA low during the ninth clock.
- R3: After any other address byte, the slave gives no acknowledge for that byte or for any later byte of the transaction, and no configuration bit changes.
- R4: The command byte (second) and the count byte (third) are acknowledged, and their values reach no register.
- R5: Data bytes 0, 1 and 2 (frame bytes 4 to 6) are stored in configuration bits 7:0, 15:8 and 23:16. Output `i` is enabled by configuration bit `i`.
- R6: Data bytes 3 to 6, and bytes beyond the tenth, are acknowledged and change no register.
- R7: While the output-enable pin is 0, all ten output enables are 0. While it is 1, each enable equals its configuration bit.
- R8: A register changes only after all eight bits of its byte have arrived. A stop in the middle of a byte leaves it unchanged.
- R9: A start condition at any point restarts the frame, so the next byte is taken as an address.
- R10: After a stop, clocked bits are neither acknowledged nor stored until the next start.
- R11: A pulse on SCL or SDA lasting fewer than `FILT_LEN` system clocks has no effect on the received data or on framing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_in | input | 1 | Serial clock line as seen at the pad |
| sda_in | input | 1 | Serial data line as seen at the pad |
| sda_pull_low | output | 1 | 1 pulls the data line low (acknowledge) |
| oe_pin | input | 1 | Hardware output enable; 0 disables every output |
| out_en | output | NUM_OUT | Per-output enable after gating |
| cfg_q | output | NUM_CFG*8 | Stored configuration word {data2, data1, data0} |

## Verification
The bench builds the block with its defaults: ten outputs, three stored bytes, address `0xD2` and a three-sample filter. With these values, a single-cycle spike is well short of the filter window, so the glitch requirement can be tested directly. A bus quarter-bit of 20 system clocks keeps the synchronizer and filter delay small against each bus phase, so the bench knows when each acknowledge must be visible. The bench's model tracks the expected configuration word from the frames it sends. It compares the model against `cfg_q` and `out_en` on every idle clock, and it checks each acknowledge bit, including repeated starts, aborted bytes and frames longer than ten bytes.

// File: rtl/smb_cfg_pkg.sv
package smb_cfg_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_DATA,
        ST_DATA_ACK,
        ST_IGNORE
    } fsm_state_t;
endpackage

// File: rtl/smb_line_filter.sv
// Two-flop synchronizer followed by a persistence filter.
module smb_line_filter #(
    parameter int FILT_LEN = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_in,
    output logic line_q
);
    localparam int CW = $clog2(FILT_LEN + 1);

    logic          sync1, sync2;
    logic [CW-1:0] run_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync1   <= 1'b1;
            sync2   <= 1'b1;
            line_q  <= 1'b1;
            run_cnt <= '0;
        end else begin
            sync1 <= line_in;
            sync2 <= sync1;
            if (sync2 == line_q) begin
                run_cnt <= '0;
            end else if (run_cnt == CW'(FILT_LEN - 1)) begin
                line_q  <= sync2;
                run_cnt <= '0;
            end else begin
                run_cnt <= run_cnt + 1'b1;
            end
        end
    end

    // A filtered change needs the raw sample to differ on the cycle before.
    assert_filter_persist_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (line_q != $past(line_q)) |-> ($past(sync2) != $past(line_q)));
endmodule

// File: rtl/smb_bus_events.sv
// Edge and bus-condition detection on the filtered lines.
module smb_bus_events (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_f,
    input  logic sda_f,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    logic scl_d, sda_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_d <= 1'b1;
            sda_d <= 1'b1;
        end else begin
            scl_d <= scl_f;
            sda_d <= sda_f;
        end
    end

    always_comb begin
        scl_rise  = scl_f & ~scl_d;
        scl_fall  = ~scl_f & scl_d;
        start_det = scl_f & scl_d & sda_d & ~sda_f;
        stop_det  = scl_f & scl_d & ~sda_d & sda_f;
    end
endmodule

// File: rtl/smb_frame_fsm.sv
// Frame-position state machine: address match, acknowledge, byte commit.
module smb_frame_fsm
    import smb_cfg_pkg::*;
#(
    parameter logic [7:0] SLAVE_ADDR  = 8'hD2,
    parameter int         NUM_CFG     = 3,
    parameter int         FRAME_BYTES = 10
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       scl_rise,
    input  logic                       scl_fall,
    input  logic                       start_det,
    input  logic                       stop_det,
    input  logic                       sda_bit,
    output logic                       sda_low,
    output logic                       wr_en,
    output logic [$clog2(NUM_CFG)-1:0] wr_sel,
    output logic [7:0]                 wr_data
);
    localparam int SELW     = $clog2(NUM_CFG);
    localparam int IDXW     = $clog2(FRAME_BYTES);
    localparam int CFG_BASE = 2;              // command and count precede the data
    localparam int IDX_MAX  = FRAME_BYTES - 1;

    fsm_state_t      state, state_n;
    logic [3:0]      bit_cnt;
    logic [7:0]      shreg;
    logic [IDXW-1:0] byte_idx;
    logic            byte_done;
    logic            cfg_slot;

    always_comb begin
        byte_done = (bit_cnt == 4'd8) && scl_fall;
        cfg_slot  = (byte_idx >= IDXW'(CFG_BASE)) &&
                    (byte_idx <  IDXW'(CFG_BASE + NUM_CFG));
    end

    // Next-state logic
    always_comb begin
        state_n = state;
        if (start_det) begin
            state_n = ST_ADDR;
        end else if (stop_det) begin
            state_n = ST_IDLE;
        end else begin
            unique case (state)
                ST_IDLE, ST_IGNORE: state_n = state;
                ST_ADDR:     if (byte_done)
                                 state_n = (shreg == SLAVE_ADDR) ? ST_ADDR_ACK : ST_IGNORE;
                ST_ADDR_ACK: if (scl_fall) state_n = ST_DATA;
                ST_DATA:     if (byte_done) state_n = ST_DATA_ACK;
                ST_DATA_ACK: if (scl_fall) state_n = ST_DATA;
                default:     state_n = ST_IDLE;
            endcase
        end
    end

    // State register and frame counters
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            bit_cnt  <= '0;
            shreg    <= '0;
            byte_idx <= '0;
        end else begin
            state <= state_n;
            if (start_det || stop_det) begin
                bit_cnt <= '0;
                if (start_det) byte_idx <= '0;
            end else if ((state == ST_ADDR || state == ST_DATA) && scl_rise &&
                         bit_cnt != 4'd8) begin
                shreg   <= {shreg[6:0], sda_bit};
                bit_cnt <= bit_cnt + 1'b1;
            end else if ((state == ST_ADDR_ACK || state == ST_DATA_ACK) && scl_fall) begin
                bit_cnt <= '0;
            end
            if (!start_det && !stop_det && state == ST_DATA && byte_done &&
                byte_idx != IDXW'(IDX_MAX))
                byte_idx <= byte_idx + 1'b1;
        end
    end

    // Registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sda_low <= 1'b0;
            wr_en   <= 1'b0;
            wr_sel  <= '0;
            wr_data <= '0;
        end else begin
            sda_low <= (state_n == ST_ADDR_ACK) || (state_n == ST_DATA_ACK);
            wr_en   <= 1'b0;
            if (!start_det && !stop_det && state == ST_DATA && byte_done && cfg_slot) begin
                wr_en   <= 1'b1;
                wr_sel  <= SELW'(byte_idx - IDXW'(CFG_BASE));
                wr_data <= shreg;
            end
        end
    end

    assert_ack_release_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ADDR_ACK && scl_fall && !start_det && !stop_det) |=> !sda_low);
    assert_no_ack_foreign_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IGNORE) |-> !sda_low);
    assert_full_byte_R8: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (bit_cnt == 4'd8));
    assert_restart_R9: assert property (@(posedge clk) disable iff (!rst_n)
        start_det |=> (state == ST_ADDR && bit_cnt == 4'd0));
    assert_stop_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_det && !start_det) |=> (state == ST_IDLE && !sda_low));
endmodule

// File: rtl/smb_cfg_slave.sv
module smb_cfg_slave #(
    parameter int         NUM_OUT     = 10,
    parameter int         NUM_CFG     = 3,
    parameter logic [7:0] SLAVE_ADDR  = 8'hD2,
    parameter int         FILT_LEN    = 3,
    parameter int         FRAME_BYTES = 10
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   scl_in,
    input  logic                   sda_in,
    output logic                   sda_pull_low,
    input  logic                   oe_pin,
    output logic [NUM_OUT-1:0]     out_en,
    output logic [NUM_CFG*8-1:0]   cfg_q
);
    localparam int SELW = $clog2(NUM_CFG);

    logic            scl_f, sda_f;
    logic            scl_rise, scl_fall, start_det, stop_det;
    logic            wr_en;
    logic [SELW-1:0] wr_sel;
    logic [7:0]      wr_data;
    logic [7:0]      cfg_r [NUM_CFG];

    smb_line_filter #(.FILT_LEN(FILT_LEN)) u_scl_filt (
        .clk(clk), .rst_n(rst_n), .line_in(scl_in), .line_q(scl_f));
    smb_line_filter #(.FILT_LEN(FILT_LEN)) u_sda_filt (
        .clk(clk), .rst_n(rst_n), .line_in(sda_in), .line_q(sda_f));

    smb_bus_events u_events (
        .clk(clk), .rst_n(rst_n), .scl_f(scl_f), .sda_f(sda_f),
        .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_det(start_det), .stop_det(stop_det));

    smb_frame_fsm #(
        .SLAVE_ADDR(SLAVE_ADDR), .NUM_CFG(NUM_CFG), .FRAME_BYTES(FRAME_BYTES)
    ) u_fsm (
        .clk(clk), .rst_n(rst_n),
        .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_det(start_det), .stop_det(stop_det), .sda_bit(sda_f),
        .sda_low(sda_pull_low),
        .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data));

    for (genvar g = 0; g < NUM_CFG; g++) begin : g_cfg
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                cfg_r[g] <= 8'hFF;
            else if (wr_en && wr_sel == SELW'(g))
                cfg_r[g] <= wr_data;
        end
        assign cfg_q[g*8 +: 8] = cfg_r[g];
    end

    for (genvar i = 0; i < NUM_OUT; i++) begin : g_out
        assign out_en[i] = oe_pin & cfg_q[i];
    end

    assert_cfg_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(cfg_q));
    assert_wr_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (wr_sel < SELW'(NUM_CFG)));
endmodule

// File: tb/smb_cfg_slave_tb.sv
module smb_cfg_slave_tb;
    localparam int Q = 20;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        m_scl = 1'b1, m_sda = 1'b1, g_scl = 1'b0, g_sda = 1'b0;
    logic        oe_pin = 1'b1;
    logic        sda_pull_low;
    logic [9:0]  out_en;
    logic [23:0] cfg_q;
    wire         scl_in = m_scl ^ g_scl;
    wire         sda_in = (m_sda ^ g_sda) & ~sda_pull_low;

    int          n_chk = 0, n_fail = 0;
    logic        model_valid = 1'b0;
    logic [23:0] exp_cfg = 24'hFFFFFF;
    logic [7:0]  fb [16];
    bit          done = 1'b0;

    always #10 clk = ~clk;

    smb_cfg_slave u_dut (
        .clk(clk), .rst_n(rst_n), .scl_in(scl_in), .sda_in(sda_in),
        .sda_pull_low(sda_pull_low), .oe_pin(oe_pin),
        .out_en(out_en), .cfg_q(cfg_q));

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] expv);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, expv);
        end
    endtask

    // Per-clock comparison against the model while the bus is idle
    always @(negedge clk) begin
        if (model_valid && rst_n) begin
            chk(cfg_q == exp_cfg, "R5", "cfg word", 32'(cfg_q), 32'(exp_cfg));
            chk(out_en == (oe_pin ? exp_cfg[9:0] : 10'h0), "R7", "out_en",
                32'(out_en), 32'(oe_pin ? exp_cfg[9:0] : 10'h0));
        end
    end

    task automatic wq(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        m_sda = 1'b1; wq(Q); m_scl = 1'b1; wq(Q);
        m_sda = 1'b0; wq(Q); m_scl = 1'b0; wq(Q);
    endtask

    task automatic bus_stop();
        m_sda = 1'b0; wq(Q); m_scl = 1'b1; wq(Q);
        m_sda = 1'b1; wq(2*Q);
    endtask

    task automatic send_bit(input logic b, input bit glitch);
        m_sda = b; wq(Q);
        if (glitch) begin
            wq(2); g_scl = 1'b1; wq(1); g_scl = 1'b0; wq(2);
        end
        m_scl = 1'b1; wq(Q);
        if (glitch) begin
            g_sda = 1'b1; wq(1); g_sda = 1'b0;
        end
        wq(Q); m_scl = 1'b0; wq(Q);
    endtask

    task automatic send_byte(input logic [7:0] b, input bit glitch, output bit ack);
        for (int k = 7; k >= 0; k--) send_bit(b[k], glitch && k == 4);
        m_sda = 1'b1; wq(Q); m_scl = 1'b1; wq(Q);
        ack = sda_pull_low;
        wq(Q); m_scl = 1'b0; wq(Q);
    endtask

    // Full frame of n bytes from fb[], with model update and ack checks
    task automatic run_frame(input int n, input bit glitch, input string tag);
        bit ack;
        bit match;
        model_valid = 1'b0;
        match = (fb[0] == 8'hD2);
        bus_start();
        for (int i = 0; i < n; i++) begin
            send_byte(fb[i], glitch && i == 3, ack);
            chk(ack == match, i == 0 ? (match ? "R2" : "R3") :
                              (match ? (i < 3 ? "R4" : "R6") : "R3"),
                $sformatf("%s ack byte %0d", tag, i), 32'(ack), 32'(match));
            if (match && i >= 3 && i <= 5) exp_cfg[(i-3)*8 +: 8] = fb[i];
        end
        bus_stop();
        wq(Q);
        model_valid = 1'b1;
        wq(Q);
    endtask

    initial begin
        bit ack;
        wq(5);
        rst_n = 1'b1;
        wq(3);
        // R1 reset state
        chk(cfg_q == 24'hFFFFFF, "R1", "reset cfg", 32'(cfg_q), 32'hFFFFFF);
        chk(out_en == 10'h3FF, "R1", "reset out_en", 32'(out_en), 32'h3FF);
        model_valid = 1'b1;
        wq(5);
        oe_pin = 1'b0; wq(2);
        chk(out_en == 10'h0, "R7", "oe low", 32'(out_en), 32'h0);
        oe_pin = 1'b1; wq(2);

        // Valid frame: R2 R4 R5 R6
        fb[0] = 8'hD2; fb[1] = 8'h5A; fb[2] = 8'h07; fb[3] = 8'h3C; fb[4] = 8'h81;
        fb[5] = 8'h96; fb[6] = 8'h11; fb[7] = 8'h22; fb[8] = 8'h33; fb[9] = 8'h44;
        run_frame(10, 1'b0, "good");
        chk(cfg_q == 24'h96813C, "R5", "stored bytes", 32'(cfg_q), 32'h96813C);
        chk(out_en == 10'h13C, "R5", "out_en map", 32'(out_en), 32'h13C);
        oe_pin = 1'b0; wq(3);
        chk(out_en == 10'h0, "R7", "oe low after write", 32'(out_en), 32'h0);
        oe_pin = 1'b1; wq(3);

        // Foreign addresses: R3
        fb[0] = 8'hD3; fb[3] = 8'h00; fb[4] = 8'h00; fb[5] = 8'h00;
        run_frame(10, 1'b0, "read bit");
        fb[0] = 8'hA4;
        run_frame(10, 1'b0, "other addr");
        chk(cfg_q == 24'h96813C, "R3", "cfg after foreign", 32'(cfg_q), 32'h96813C);

        // Twelve-byte frame: R6 extra bytes acknowledged and ignored
        fb[0] = 8'hD2; fb[3] = 8'h0F; fb[4] = 8'h02; fb[5] = 8'h55;
        fb[10] = 8'hEE; fb[11] = 8'hDD;
        run_frame(12, 1'b0, "long");
        chk(cfg_q == 24'h55020F, "R6", "cfg after long frame", 32'(cfg_q), 32'h55020F);

        // Stop inside data byte 0: R8
        model_valid = 1'b0;
        bus_start();
        send_byte(8'hD2, 1'b0, ack);
        send_byte(8'h00, 1'b0, ack);
        send_byte(8'h00, 1'b0, ack);
        for (int k = 0; k < 4; k++) send_bit(1'b0, 1'b0);
        bus_stop();
        wq(Q);
        chk(cfg_q == 24'h55020F, "R8", "partial byte", 32'(cfg_q), 32'h55020F);
        model_valid = 1'b1; wq(Q);

        // Repeated start after the command byte: R9
        model_valid = 1'b0;
        bus_start();
        send_byte(8'hD2, 1'b0, ack);
        send_byte(8'h12, 1'b0, ack);
        bus_start();
        send_byte(8'hD2, 1'b0, ack);
        chk(ack == 1'b1, "R9", "address after restart ack", 32'(ack), 32'h1);
        send_byte(8'h34, 1'b0, ack);
        send_byte(8'h03, 1'b0, ack);
        send_byte(8'hF0, 1'b0, ack);
        bus_stop();
        exp_cfg[7:0] = 8'hF0;
        wq(Q);
        chk(cfg_q == 24'h5502F0, "R9", "cfg after restart", 32'(cfg_q), 32'h5502F0);
        model_valid = 1'b1; wq(Q);

        // Bits clocked after a stop, with no start: R10
        send_byte(8'hD2, 1'b0, ack);
        chk(ack == 1'b0, "R10", "no ack while idle", 32'(ack), 32'h0);
        send_byte(8'h00, 1'b0, ack);
        chk(ack == 1'b0, "R10", "no ack while idle 2", 32'(ack), 32'h0);
        bus_stop();
        chk(cfg_q == 24'h5502F0, "R10", "cfg unchanged idle", 32'(cfg_q), 32'h5502F0);

        // Short spikes on both lines inside data byte 0: R11
        fb[0] = 8'hD2; fb[3] = 8'hA5; fb[4] = 8'h01; fb[5] = 8'h7E;
        run_frame(10, 1'b1, "glitch");
        chk(cfg_q == 24'h7E01A5, "R11", "cfg with spikes", 32'(cfg_q), 32'h7E01A5);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule